// File: doc/BRIEF.md
# Boot and Block Write-Protect Gate

This block decides whether a program or erase request aimed at one flash sector may go ahead. Two active-low hardware protect pins are each combined with software lock bits: the top-boot pin with a single boot-region lock bit, and the write-protect pin with one lock bit per 64 KB block. A pin held low protects its region whatever its lock bits hold, and a pin held high leaves protection to those bits. The pins work independently of each other. Because pin and lock bit are simply ORed, software that clears a lock bit while the pin is low sees the bit read back as clear, but writes stay denied.

A request is a one-cycle strobe carrying a sector address. The gate samples the pins and lock bits on that edge and answers on the same edge: either it raises the array write-enable for a fixed operation window, or it gives a one-cycle deny pulse and no write-enable. Later pin or lock changes cannot shorten a window that has already started. The lock-bit write and readback path is part of the block. The boot region is the top `BOOT_SECT` sectors of the array. That is 16 sectors (64 KB) by default, and 4 sectors (16 KB) in the smallest array size.

Top module: `wp_gate`

## Requirements
- R1: After reset `wr_en` and `deny` are 0 and every lock bit (block bits at `lk_sel` 0..NUM_BLK-1, boot bit at `lk_sel` = NUM_BLK) reads back 1.
- R2: With `lk_we` high, `lk_wdata` is written on the clock edge to the lock bit chosen by `lk_sel` (0..NUM_BLK-1 is block lock n, NUM_BLK is the boot lock). `lk_rdata` shows the selected bit without delay. A `lk_sel` above NUM_BLK reads 0, and writing to it changes no bit.
- R3: A sector address `req_sect` >= 2^SECT_W - BOOT_SECT is in the boot region. While `tbl_n` is 0, a request there is denied whatever the boot lock holds.
- R4: While `tbl_n` is 1, a boot-region request is granted when the boot lock is 0 and denied when it is 1.
- R5: Outside the boot region, a request is denied if `wp_n` is 0 or if the lock bit of block `req_sect[SECT_W-1:BLK_SH]` is 1. Otherwise it is granted.
- R6: `tbl_n` has no effect on requests outside the boot region, and `wp_n` has no effect on boot-region requests.
- R7: A lock bit cleared while its pin is 0 reads back 0, but requests to its region are still denied.
- R8: A request is taken on the edge where `req` is high. A grant raises `wr_en` on that edge for exactly OP_CYCLES cycles. A deny raises `deny` on that edge for one cycle with no `wr_en`. The two are never high together.
- R9: Pin and lock changes made while `wr_en` is high do not end or extend the window.
- R10: A request that arrives while `wr_en` is high is ignored. It causes no deny pulse and does not lengthen the window.
- R11: A lock write on the same edge as a request does not affect that request. The request is decided on the lock value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Program/erase request strobe |
| req_sect | input | SECT_W | Sector address of the request |
| tbl_n | input | 1 | Boot-region protect pin, active low |
| wp_n | input | 1 | Protect pin for all other blocks, active low |
| lk_we | input | 1 | Lock-bit write strobe |
| lk_sel | input | SEL_W | Lock-bit select (block index, or NUM_BLK for the boot lock) |
| lk_wdata | input | 1 | Value to write to the selected lock bit |
| lk_rdata | output | 1 | Readback of the selected lock bit |
| wr_en | output | 1 | Array write-enable, held for the operation window |
| deny | output | 1 | One-cycle pulse for a refused request |

## Verification
The bench goes after the OR between pin and lock. It clears a lock bit while the matching pin is low and expects the bit to read 0 but the request still to be denied; a design that let the register override the pin would grant it. It cross-checks the two pins on the other region's addresses, so a design that mixed them up would deny requests it should grant. It drops both pins in the middle of a window and strobes a second request inside it; a design that re-evaluated protection every cycle, or re-armed its counter, would cut the window short or stretch it. It also writes a lock bit on the same edge as a request; a design that forwarded the new value would answer with the wrong decision.

// File: rtl/wp_gate.sv
module wp_gate #(
  parameter int SECT_W    = 8,
  parameter int BLK_SH    = 4,
  parameter int BOOT_SECT = 16,
  parameter int OP_CYCLES = 8,
  localparam int NUM_BLK  = 1 << (SECT_W - BLK_SH),
  localparam int IDX_W    = SECT_W - BLK_SH,
  localparam int SEL_W    = $clog2(NUM_BLK + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [SECT_W-1:0] req_sect,
  input  logic              tbl_n,
  input  logic              wp_n,
  input  logic              lk_we,
  input  logic [SEL_W-1:0]  lk_sel,
  input  logic              lk_wdata,
  output logic              lk_rdata,
  output logic              wr_en,
  output logic              deny
);
  localparam int BOOT_BASE = (1 << SECT_W) - BOOT_SECT;
  localparam int CW = $clog2(OP_CYCLES + 1);
  localparam logic [SECT_W:0] BASE_V = BOOT_BASE[SECT_W:0];
  localparam logic [SEL_W-1:0] BOOT_SEL = NUM_BLK[SEL_W-1:0];

  logic [NUM_BLK-1:0] blk_lk;
  logic               boot_lk;
  logic [CW-1:0]      cnt;

  wire             in_boot = {1'b0, req_sect} >= BASE_V;
  wire [IDX_W-1:0] blk_idx = req_sect[SECT_W-1:BLK_SH];
  wire             sel_blk = lk_sel < BOOT_SEL;
  wire             guarded = in_boot ? (~tbl_n | boot_lk) : (~wp_n | blk_lk[blk_idx]);
  wire             take    = req & ~wr_en;

  assign lk_rdata = sel_blk ? blk_lk[lk_sel[IDX_W-1:0]]
                  : (lk_sel == BOOT_SEL) ? boot_lk : 1'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_lk  <= '1;
      boot_lk <= 1'b1;
    end else if (lk_we) begin
      if (sel_blk) blk_lk[lk_sel[IDX_W-1:0]] <= lk_wdata;
      else if (lk_sel == BOOT_SEL) boot_lk <= lk_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_en <= 1'b0;
      deny  <= 1'b0;
      cnt   <= '0;
    end else begin
      deny <= take & guarded;
      if (take && !guarded) begin
        wr_en <= 1'b1;
        cnt   <= CW'(OP_CYCLES - 1);
      end else if (wr_en) begin
        if (cnt == '0) wr_en <= 1'b0;
        else cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

module wp_gate_chk #(
  parameter int SECT_W    = 8,
  parameter int BOOT_SECT = 16,
  parameter int OP_CYCLES = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic [SECT_W-1:0] req_sect,
  input logic              tbl_n,
  input logic              wp_n,
  input logic              wr_en,
  input logic              deny
);
  localparam int BOOT_BASE = (1 << SECT_W) - BOOT_SECT;
  wire boot_hit = int'(req_sect) >= BOOT_BASE;
  int run;

  always_ff @(posedge clk) begin
    if (!rst_n || !wr_en) run <= 0;
    else run <= run + 1;
  end

  // R8: grant and deny are exclusive
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n) !(wr_en && deny));
  // R8: a deny pulse follows a request taken while idle
  a_r8_deny_src: assert property (@(posedge clk) disable iff (!rst_n)
    deny |-> ($past(req) && !$past(wr_en)));
  // R8: a window only opens on a request
  a_r8_grant_src: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_en) |-> $past(req));
  // R8, R9: window length exactly OP_CYCLES
  a_r9_window_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_en) |-> run == OP_CYCLES);
  a_r10_no_stretch: assert property (@(posedge clk) disable iff (!rst_n) run <= OP_CYCLES);
  // R3: boot pin low always denies boot requests
  a_r3_boot_pin: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !wr_en && !tbl_n && boot_hit) |=> deny);
  // R5: block pin low always denies other requests
  a_r5_wp_pin: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !wr_en && !wp_n && !boot_hit) |=> deny);
  // R10: a request during a window gives no deny
  a_r10_busy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (req && wr_en) |=> !deny);
endmodule

bind wp_gate wp_gate_chk #(.SECT_W(SECT_W), .BOOT_SECT(BOOT_SECT), .OP_CYCLES(OP_CYCLES))
  u_chk (.clk(clk), .rst_n(rst_n), .req(req), .req_sect(req_sect), .tbl_n(tbl_n),
         .wp_n(wp_n), .wr_en(wr_en), .deny(deny));

// File: tb/wp_gate_test.sv
module wp_gate_test;
  localparam int SECT_W = 8, BLK_SH = 4, BOOT_SECT = 16, OP = 8;
  localparam int NUM_BLK = 16, SEL_W = 5;

  logic clk = 0, rst_n = 0, req = 0, tbl_n = 1, wp_n = 1, lk_we = 0, lk_wdata = 0;
  logic [SECT_W-1:0] req_sect = '0;
  logic [SEL_W-1:0] lk_sel = '0;
  logic lk_rdata, wr_en, deny;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wp_gate #(.SECT_W(SECT_W), .BLK_SH(BLK_SH), .BOOT_SECT(BOOT_SECT), .OP_CYCLES(OP)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_sect(req_sect), .tbl_n(tbl_n), .wp_n(wp_n),
    .lk_we(lk_we), .lk_sel(lk_sel), .lk_wdata(lk_wdata), .lk_rdata(lk_rdata),
    .wr_en(wr_en), .deny(deny));

  task automatic chk(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic lock_wr(input int sel, input logic v);
    @(negedge clk); lk_we = 1; lk_sel = SEL_W'(sel); lk_wdata = v;
    @(negedge clk); lk_we = 0;
  endtask

  task automatic lock_rd(input int sel, input logic exp, input string tag);
    @(negedge clk); lk_sel = SEL_W'(sel); #1;
    chk(lk_rdata, exp, tag);
  endtask

  // mode 0 plain, 1 drop pins and flip locks mid-window, 2 extra request mid-window
  task automatic do_req(input int sect, input logic grant, input int mode, input string tag);
    logic t0 = tbl_n, w0 = wp_n;
    @(negedge clk); req = 1; req_sect = SECT_W'(sect);
    @(posedge clk); #1;
    chk(wr_en, grant, {tag, " R8 wr_en"});
    chk(deny, !grant, {tag, " R8 deny"});
    @(negedge clk); req = 0;
    if (grant) begin
      for (int i = 1; i < OP; i++) begin
        if (i > 1) @(negedge clk);
        if (mode == 1) begin tbl_n = 0; wp_n = 0; lk_we = 1; lk_sel = 3; lk_wdata = 1; end
        req = (mode == 2 && i == 2);
        @(posedge clk); #1;
        chk(wr_en, 1'b1, {tag, " R9 window held"});
        chk(deny, 1'b0, {tag, " R10 no deny in window"});
      end
      @(negedge clk); req = 0; lk_we = 0;
      @(posedge clk); #1;
      chk(wr_en, 1'b0, {tag, " R8 R10 window ends"});
      tbl_n = t0; wp_n = w0;
    end else begin
      @(posedge clk); #1;
      chk(deny, 1'b0, {tag, " R8 deny one cycle"});
    end
  endtask

  task automatic t_reset();
    chk(wr_en, 1'b0, "R1 wr_en");
    chk(deny, 1'b0, "R1 deny");
    for (int s = 0; s <= NUM_BLK; s++) lock_rd(s, 1'b1, "R1 lock reset");
    lock_rd(NUM_BLK + 1, 1'b0, "R2 unused select");
  endtask

  task automatic t_locks();
    lock_wr(3, 0);  lock_rd(3, 1'b0, "R2 block clear");
    lock_rd(4, 1'b1, "R2 neighbour kept");
    lock_wr(NUM_BLK, 0); lock_rd(NUM_BLK, 1'b0, "R2 boot clear");
    lock_wr(NUM_BLK, 1); lock_rd(NUM_BLK, 1'b1, "R2 boot set");
    lock_wr(NUM_BLK + 3, 0);
    lock_rd(NUM_BLK + 3, 1'b0, "R2 unused select write");
    for (int s = 0; s < NUM_BLK; s++) if (s != 3) lock_rd(s, 1'b1, "R2 no stray write");
  endtask

  task automatic t_boot();
    lock_wr(NUM_BLK, 0);
    tbl_n = 0; do_req(8'hF5, 0, 0, "R3 pin low boot");
    do_req(8'hF0, 0, 0, "R3 boot base");
    tbl_n = 1; do_req(8'hF5, 1, 0, "R4 pin high unlocked");
    do_req(8'hEF, 0, 0, "R5 just below boot uses block lock");
    lock_wr(NUM_BLK, 1); do_req(8'hFF, 0, 0, "R4 pin high locked");
  endtask

  task automatic t_blocks();
    wp_n = 1; do_req(8'h3A, 1, 0, "R5 unlocked block");
    wp_n = 0; do_req(8'h3A, 0, 0, "R5 pin low");
    wp_n = 1; do_req(8'h45, 0, 0, "R5 locked block");
  endtask

  task automatic t_indep();
    lock_wr(NUM_BLK, 0);
    wp_n = 0; tbl_n = 1; do_req(8'hF2, 1, 0, "R6 wp_n ignored in boot");
    wp_n = 1; tbl_n = 0; do_req(8'h31, 1, 0, "R6 tbl_n ignored outside boot");
    tbl_n = 1; lock_wr(NUM_BLK, 1);
  endtask

  task automatic t_clear_under_pin();
    tbl_n = 0; lock_wr(NUM_BLK, 0);
    lock_rd(NUM_BLK, 1'b0, "R7 boot readback");
    do_req(8'hF9, 0, 0, "R7 boot still denied");
    tbl_n = 1; lock_wr(NUM_BLK, 1);
    wp_n = 0; lock_wr(7, 0);
    lock_rd(7, 1'b0, "R7 block readback");
    do_req(8'h70, 0, 0, "R7 block still denied");
    wp_n = 1; do_req(8'h70, 1, 0, "R7 released pin grants");
  endtask

  task automatic t_midop();
    do_req(8'h33, 1, 1, "R9 pins dropped");
    do_req(8'h33, 0, 0, "R9 lock written in window applies next");
    lock_wr(3, 0);
  endtask

  task automatic t_busy();
    do_req(8'h34, 1, 2, "R10 request in window");
  endtask

  task automatic t_same_cycle();
    @(negedge clk); req = 1; req_sect = 8'h36; lk_we = 1; lk_sel = 3; lk_wdata = 1;
    @(posedge clk); #1;
    chk(wr_en, 1'b1, "R11 old unlocked value used");
    @(negedge clk); req = 0; lk_we = 0;
    repeat (OP) @(negedge clk);
    @(negedge clk); req = 1; lk_we = 1; lk_wdata = 0;
    @(posedge clk); #1;
    chk(deny, 1'b1, "R11 old locked value used");
    @(negedge clk); req = 0; lk_we = 0;
    lock_rd(3, 1'b0, "R11 write still landed");
  endtask

  initial begin
    #1000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    t_reset();
    t_locks();
    t_boot();
    t_blocks();
    t_indep();
    t_clear_under_pin();
    t_midop();
    t_busy();
    t_same_cycle();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule